// File: doc/BRIEF.md
# Multi-Channel Down-Counting Interval Timer

This block holds a bank of independent down-counters behind a small 32-bit register bus. Each channel has a control word, a reload interval and a current count that software can read and overwrite at any time. When running, a channel decrements once per tick. A tick is derived from one of several clock-source enable inputs, divided by a power-of-two prescaler. A channel expires on the tick that brings its count to zero. It then either reloads from its interval register or goes to zero. In single-shot mode it also stops itself.

A shared enable register and a shared pending register collect the expiry events of all channels. Pending bits are cleared by writing ones. A single interrupt output is high while any enabled channel has a pending event. Reads are combinational from the address; writes take effect at the clock edge on which the write strobe is high.

Top module: `ivtimer_bank`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: Word offsets: 0x00 interrupt enable (bit n for channel n), 0x04 pending status, and for channel n the control word at 0x10+0x10*n, the interval at 0x14+0x10*n and the count at 0x18+0x10*n. Any other offset, including an unaligned one, or a channel window beyond the last channel, reads zero.
- R3: Control word bits: 0 run, 1 reload, 3:2 source select, 6:4 prescale exponent k, 7 single-shot (1) or continuous (0). These eight bits read back as written, and bits 31:8 read zero.
- R4: A running channel counts once every 2^k pulses of its selected source. The first count falls on the 2^k-th pulse after the run bit is set.
- R5: Only the `src_en` bit chosen by the source-select field advances a channel.
- R6: On each count the value drops by one. The count that finds a value of 1 or 0 is an expiry, so a channel started at N with k = 0 and a source that pulses every cycle expires N cycles after its start write.
- R7: On expiry the count becomes the interval value when reload is set, and zero otherwise. In single-shot mode the run bit clears on expiry.
- R8: In continuous mode with reload, a channel expires repeatedly with a period of interval counts.
- R9: In continuous mode without reload, the channel stays at zero with the run bit set and expires again on every further count.
- R10: A write to the count register takes effect on its edge, even while the channel is running, and overrides that edge's decrement.
- R11: A channel whose run bit is clear holds its count.
- R12: A pending bit is set on expiry whether or not it is enabled. Writing 1 clears it. An expiry on the same edge as the clear leaves it set.
- R13: `irq` is high exactly when some channel has both its pending bit and its enable bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_en | input | NSRC (4) | Per-source tick enables, one pulse per clock cycle high |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | AW (8) | Byte address |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Read data for `bus_addr`, combinational |
| irq | output | 1 | Combined interrupt |

## Verification
The expiry time of single-shot runs is swept over every prescale exponent and several start counts on rotating channels, with the source pulsing every cycle. The measured delay of N times 2^k separates an off-by-one in the prescaler or the zero test from a correct design. Sparse pulses on an unselected source, and then on a selected one, show whether the channel counts source pulses or clock cycles. The three expiry flavours (single-shot with reload, continuous with reload, continuous without reload) are each followed through their reload value and run bit. A clear of a pending bit is placed on the same edge as an expiry, and a count write on the same edge as a decrement, to expose the wrong priority on either.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

    // Widths of the control word fields
    localparam int IVT_PW = 3;   // prescale exponent bits
    localparam int IVT_SW = 2;   // source select bits

    // Control word, bit 0 first from the LSB: run, reload, source, prescale, single
    typedef struct packed {
        logic              single;
        logic [IVT_PW-1:0] presc;
        logic [IVT_SW-1:0] clksel;
        logic              reload;
        logic              run;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    // Register select inside a channel window (address bits 3:2)
    localparam logic [1:0] SEL_CTRL = 2'd0;
    localparam logic [1:0] SEL_IVAL = 2'd1;
    localparam logic [1:0] SEL_CUR  = 2'd2;

endpackage

// File: rtl/ivt_prescaler.sv
module ivt_prescaler
    import ivt_pkg::*;
#(
    parameter int NSRC = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    input  logic [NSRC-1:0]     src_en,
    input  logic [IVT_SW-1:0]   clksel,
    input  logic [IVT_PW-1:0]   presc,
    output logic                tick
);

    localparam int CW = (1 << IVT_PW) - 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
    } pre_t;

    pre_t          s_d, s_q;
    logic          pulse;
    logic [CW-1:0] mask;

    always_comb begin
        pulse = run && src_en[clksel];
        mask  = CW'((32'd1 << presc) - 32'd1);
        tick  = pulse && ((s_q.cnt & mask) == mask);
        s_d   = s_q;
        if (!run) begin
            s_d.cnt = '0;
        end else if (pulse) begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/ivt_channel.sv
module ivt_channel
    import ivt_pkg::*;
#(
    parameter int DW   = 32,
    parameter int NSRC = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_en,
    input  logic            wr_ctrl,
    input  logic            wr_ival,
    input  logic            wr_cur,
    input  logic [DW-1:0]   wdata,
    output ctrl_t           ctrl,
    output logic [DW-1:0]   ival,
    output logic [DW-1:0]   cur,
    output logic            expire
);

    typedef struct packed {
        ctrl_t         ctrl;
        logic [DW-1:0] ival;
        logic [DW-1:0] cur;
    } chan_t;

    chan_t s_d, s_q;
    logic  tick;

    ivt_prescaler #(
        .NSRC (NSRC)
    ) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (s_q.ctrl.run),
        .src_en (src_en),
        .clksel (s_q.ctrl.clksel),
        .presc  (s_q.ctrl.presc),
        .tick   (tick)
    );

    always_comb begin
        s_d    = s_q;
        expire = 1'b0;
        if (tick) begin
            if (s_q.cur <= DW'(1)) begin
                expire = 1'b1;
                s_d.cur = s_q.ctrl.reload ? s_q.ival : '0;
                if (s_q.ctrl.single) begin
                    s_d.ctrl.run = 1'b0;
                end
            end else begin
                s_d.cur = s_q.cur - DW'(1);
            end
        end
        if (wr_ctrl) begin
            s_d.ctrl = ctrl_t'(wdata[CTRL_W-1:0]);
        end
        if (wr_ival) begin
            s_d.ival = wdata;
        end
        if (wr_cur) begin
            s_d.cur = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ctrl = s_q.ctrl;
    assign ival = s_q.ival;
    assign cur  = s_q.cur;

    // R7
    single_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && s_q.ctrl.single && !wr_ctrl) |=> !s_q.ctrl.run);

    // R11
    hold_when_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.ctrl.run && !wr_cur) |=> $stable(s_q.cur));

    // R6
    step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (s_q.cur > DW'(1)) && !wr_cur) |=> (s_q.cur == $past(s_q.cur) - DW'(1)));

endmodule

// File: rtl/ivt_irq.sv
module ivt_irq #(
    parameter int NCH = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] expire,
    input  logic           wr_en,
    input  logic           wr_pend,
    input  logic [NCH-1:0] wdata,
    output logic [NCH-1:0] en,
    output logic [NCH-1:0] pend,
    output logic           irq
);

    typedef struct packed {
        logic [NCH-1:0] en;
        logic [NCH-1:0] pend;
    } irq_t;

    irq_t           s_d, s_q;
    logic [NCH-1:0] clr;

    always_comb begin
        s_d    = s_q;
        clr    = wr_pend ? wdata : '0;
        if (wr_en) begin
            s_d.en = wdata;
        end
        s_d.pend = (s_q.pend & ~clr) | expire;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign en   = s_q.en;
    assign pend = s_q.pend;
    assign irq  = |(s_q.pend & s_q.en);

    // R12
    pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|expire) |=> ((s_q.pend & $past(expire)) == $past(expire)));

    // R12
    pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pend && !(|expire)) |=> ((s_q.pend & $past(wdata)) == '0));

endmodule

// File: rtl/ivtimer_bank.sv
module ivtimer_bank
    import ivt_pkg::*;
#(
    parameter int NCH  = 6,
    parameter int DW   = 32,
    parameter int AW   = 8,
    parameter int NSRC = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_en,
    input  logic            bus_wr,
    input  logic [AW-1:0]   bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    output logic            irq
);

    localparam int WW = AW - 4;   // window index width

    logic [WW-1:0]  win;
    logic [1:0]     sel;
    logic           aligned;
    logic           hit_en;
    logic           hit_pend;

    ctrl_t          ch_ctrl [NCH];
    logic [DW-1:0]  ch_ival [NCH];
    logic [DW-1:0]  ch_cur  [NCH];
    logic [NCH-1:0] ch_exp;
    logic [NCH-1:0] en_v;
    logic [NCH-1:0] pend_v;

    always_comb begin
        win      = bus_addr[AW-1:4];
        sel      = bus_addr[3:2];
        aligned  = (bus_addr[1:0] == 2'b00);
        hit_en   = aligned && (bus_addr[AW-1:2] == (AW-2)'(0));
        hit_pend = aligned && (bus_addr[AW-1:2] == (AW-2)'(1));
    end

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic hit;
        assign hit = aligned && (win == WW'(i + 1));

        ivt_channel #(
            .DW   (DW),
            .NSRC (NSRC)
        ) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .src_en  (src_en),
            .wr_ctrl (bus_wr && hit && (sel == SEL_CTRL)),
            .wr_ival (bus_wr && hit && (sel == SEL_IVAL)),
            .wr_cur  (bus_wr && hit && (sel == SEL_CUR)),
            .wdata   (bus_wdata),
            .ctrl    (ch_ctrl[i]),
            .ival    (ch_ival[i]),
            .cur     (ch_cur[i]),
            .expire  (ch_exp[i])
        );
    end

    ivt_irq #(
        .NCH (NCH)
    ) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .expire  (ch_exp),
        .wr_en   (bus_wr && hit_en),
        .wr_pend (bus_wr && hit_pend),
        .wdata   (bus_wdata[NCH-1:0]),
        .en      (en_v),
        .pend    (pend_v),
        .irq     (irq)
    );

    always_comb begin
        bus_rdata = '0;
        if (hit_en) begin
            bus_rdata[NCH-1:0] = en_v;
        end
        if (hit_pend) begin
            bus_rdata[NCH-1:0] = pend_v;
        end
        for (int i = 0; i < NCH; i++) begin
            if (aligned && (win == WW'(i + 1))) begin
                case (sel)
                    SEL_CTRL: bus_rdata[CTRL_W-1:0] = ch_ctrl[i];
                    SEL_IVAL: bus_rdata = ch_ival[i];
                    SEL_CUR:  bus_rdata = ch_cur[i];
                    default:  bus_rdata = '0;
                endcase
            end
        end
    end

    // R13
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((en_v & pend_v) != '0));

endmodule

// File: tb/sim_ivtimer_bank.sv
module sim_ivtimer_bank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  src_en = 4'b0010;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        irq;

    int nvec = 0;
    int nfail = 0;

    always #5 clk = ~clk;

    ivtimer_bank u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_en    (src_en),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    function automatic logic [7:0] a_ctl(int n);  return 8'(8'h10 + 8'h10 * n); endfunction
    function automatic logic [7:0] a_ival(int n); return 8'(8'h14 + 8'h10 * n); endfunction
    function automatic logic [7:0] a_cur(int n);  return 8'(8'h18 + 8'h10 * n); endfunction

    function automatic logic [31:0] ctl(bit run, bit rl, int src, int k, bit single);
        return {24'h0, single, 3'(k), 2'(src), rl, run};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Called at a negedge; the write lands on the next posedge.
    task automatic wr(logic [7:0] a, logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    initial begin
        #1_000_000;
        nfail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [31:0] held;
        int n;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(8'h00, v); check("R1 enable", v, 0);
        rd(8'h04, v); check("R1 pending", v, 0);
        rd(a_ctl(0), v); check("R1 ctrl0", v, 0);
        rd(a_ival(5), v); check("R1 ival5", v, 0);
        rd(a_cur(5), v); check("R1 cur5", v, 0);
        check("R1 irq", {31'h0, irq}, 0);

        // R2 map and R3 control layout
        for (int c = 0; c < 6; c++) wr(a_ival(c), 32'hA5A50000 + c);
        for (int c = 0; c < 6; c++) begin
            rd(a_ival(c), v); check("R2 ival readback", v, 32'hA5A50000 + c);
        end
        wr(a_ctl(2), 32'hFFFF_FFF6);
        rd(a_ctl(2), v); check("R3 ctrl fields", v, 32'h0000_00F6);
        wr(a_ctl(2), 0);
        rd(8'h1C, v); check("R2 unused slot", v, 0);
        rd(8'h08, v); check("R2 unused low", v, 0);
        rd(8'h70, v); check("R2 window past last", v, 0);
        rd(8'h15, v); check("R2 unaligned", v, 0);

        // R4 R6 R7 sweep: single-shot expiry after N * 2^k cycles
        for (int k = 0; k < 8; k++) begin
            for (int j = 0; j < 3; j++) begin
                int ch = (k + j) % 6;
                int nn = (j == 0) ? 1 : (j == 1) ? 2 : 5;
                wr(a_ctl(ch), 0);
                wr(8'h04, 32'h3F);
                wr(8'h00, 32'(1 << ch));
                wr(a_cur(ch), nn);
                wr(a_ctl(ch), ctl(1, 0, 1, k, 1));
                n = 0;
                while (n < 2000) begin
                    @(posedge clk); n++;
                    @(negedge clk);
                    if (irq) break;
                end
                check($sformatf("R4 R6 expiry k=%0d N=%0d", k, nn), n, nn * (1 << k));
                if (j == 2) begin
                    rd(a_ctl(ch), v); check("R7 single run cleared", v & 1, 0);
                    rd(a_cur(ch), v); check("R7 single no reload zero", v, 0);
                end
            end
        end
        wr(8'h04, 32'h3F);

        // R8 continuous with reload, R12 clear/set priority, R11 stop
        wr(8'h00, 32'h1);
        wr(a_ival(0), 4);
        wr(a_cur(0), 4);
        wr(a_ctl(0), ctl(1, 1, 1, 0, 0));
        repeat (3) @(negedge clk);
        check("R8 no early expiry", {31'h0, irq}, 0);
        @(negedge clk);
        check("R8 first expiry", {31'h0, irq}, 1);
        rd(a_cur(0), v); check("R8 reload value", v, 4);
        repeat (3) @(negedge clk);
        wr(8'h04, 32'h1);
        rd(8'h04, v); check("R12 expiry beats clear", v & 1, 1);
        wr(8'h04, 32'h1);
        rd(8'h04, v); check("R12 write one clears", v & 1, 0);
        rd(a_cur(0), v); check("R8 counting after reload", v, 3);
        wr(a_ctl(0), ctl(0, 1, 1, 0, 0));
        rd(a_cur(0), held); check("R11 value at stop", held, 2);
        repeat (10) @(negedge clk);
        rd(a_cur(0), v); check("R11 held while stopped", v, held);

        // R9 continuous without reload
        wr(8'h04, 32'h3F);
        wr(8'h00, 32'h2);
        wr(a_cur(1), 2);
        wr(a_ctl(1), ctl(1, 0, 1, 0, 0));
        repeat (2) @(negedge clk);
        check("R9 expiry", {31'h0, irq}, 1);
        rd(a_cur(1), v); check("R9 at zero", v, 0);
        rd(a_ctl(1), v); check("R9 run stays set", v & 1, 1);
        wr(8'h04, 32'h2);
        rd(8'h04, v); check("R9 re-expires each count", v & 2, 2);
        wr(a_ctl(1), 0);
        wr(8'h04, 32'h3F);

        // R7 single-shot with reload
        wr(a_ival(2), 7);
        wr(a_cur(2), 1);
        wr(a_ctl(2), ctl(1, 1, 1, 0, 1));
        @(negedge clk);
        rd(a_cur(2), v); check("R7 single reload value", v, 7);
        rd(a_ctl(2), v); check("R7 single reload run cleared", v & 1, 0);
        repeat (3) @(negedge clk);
        rd(a_cur(2), v); check("R11 single stopped holds", v, 7);

        // R10 count write while running, R6 step
        wr(a_cur(3), 100);
        wr(a_ctl(3), ctl(1, 0, 1, 0, 0));
        rd(a_cur(3), v); check("R6 start value", v, 100);
        repeat (5) @(negedge clk);
        rd(a_cur(3), v); check("R6 five steps", v, 95);
        wr(a_cur(3), 10);
        rd(a_cur(3), v); check("R10 write overrides step", v, 10);
        wr(a_ctl(3), 0);

        // R5 source select, R4 with sparse pulses
        wr(a_cur(4), 50);
        wr(a_ctl(4), ctl(1, 0, 2, 0, 0));
        repeat (10) @(negedge clk);
        rd(a_cur(4), v); check("R5 idle source no count", v, 50);
        for (int p = 0; p < 3; p++) begin
            src_en[2] = 1'b1; @(negedge clk);
            src_en[2] = 1'b0; @(negedge clk);
        end
        rd(a_cur(4), v); check("R5 selected source counts", v, 47);
        wr(a_ctl(4), 0);
        wr(a_cur(5), 40);
        wr(a_ctl(5), ctl(1, 0, 3, 1, 0));
        for (int p = 0; p < 6; p++) begin
            src_en[3] = 1'b1; @(negedge clk);
            src_en[3] = 1'b0; @(negedge clk); @(negedge clk);
        end
        rd(a_cur(5), v); check("R4 sparse pulses k=1", v, 37);
        wr(a_ctl(5), 0);

        // R12 R13 enable gating
        wr(8'h04, 32'h3F);
        wr(8'h00, 0);
        wr(a_cur(5), 1);
        wr(a_ctl(5), ctl(1, 0, 1, 0, 1));
        @(negedge clk);
        check("R13 masked pending", {31'h0, irq}, 0);
        rd(8'h04, v); check("R12 set while disabled", v, 32'h20);
        wr(8'h00, 32'h20);
        check("R13 enabled pending", {31'h0, irq}, 1);
        wr(8'h00, 32'h1F);
        check("R13 other enables only", {31'h0, irq}, 0);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

endmodule